// File: doc/BRIEF.md
# Register Consumer Table Chain Linker

This block sits in the decode/dispatch stage of a core whose instruction window holds operands in place and delivers results along linked lists of consumers instead of by broadcast. For every architectural register it remembers the operand slot in the window that last touched that register. That slot is either a producer's destination field or an earlier reader's source field. A window slot address is the dispatching instruction's window index followed by a two-bit field code.

When a dispatched instruction reads a register whose producer is still in flight, the block emits a link write. The link write places a pointer to the new source slot into the remembered slot, which appends the reader to the register's consumer chain. The new slot then becomes the remembered one. The block also presents the remembered slot on a probe port, so that a result already sitting there is captured at once. When the register's last writer has committed, the source reads the architectural register file instead. It is ready at dispatch and no link is made.

Destination writes claim the entry for the new producer. Commits hand the entry back to the register file only if the committing instruction is still the recorded writer. A flush returns the whole table to the committed state in one cycle.

Top module: `rct_chain_linker`

## Requirements
- R1: After reset every register is in the committed state. A valid source reads the register file: from_arf=1, ready=1, data equals the register file input, and no link write occurs.
- R2: A source whose register is committed causes no link write and leaves that entry unchanged. When both sources name committed registers, each takes its own register file data, and later readers of those registers still go to the register file.
- R3: A slot address is {window index, field}, with field S1=0, S2=1 and D=2. After an instruction with a valid destination dispatches, that register's entry holds the instruction's D slot and is in flight. The next reader's link write therefore targets {idx, 2}.
- R4: A source of an in-flight register raises its link write enable, targets the entry's current slot and carries its own slot as the pointer. The entry then moves to that source slot, so the next reader links behind it.
- R5: The probe output of each source shows the entry's current slot. For an in-flight register the source's ready and data follow the probe hit and probe data inputs.
- R6: Within one instruction, source lookups use the table state from before that instruction's own destination update.
- R7: When both sources name the same in-flight register, S1 links from the entry's slot and S2 links from the same instruction's S1 slot. The entry ends on the S2 slot, and S2's ready and data mirror S1's.
- R8: A commit returns a register to the committed state only when the committing window index equals the recorded writer of that register. A commit naming any other index leaves the entry in flight.
- R9: A flush returns every entry to the committed state in one cycle. A dispatch presented in the flush cycle produces no link write and leaves the table untouched.
- R10: If a commit of the recorded writer and a dispatch of a new writer of the same register happen in the same cycle, the new writer takes the entry and it stays in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Return all entries to committed state |
| disp_valid_i | input | 1 | An instruction dispatches this cycle |
| disp_idx_i | input | IDX_W | Window index of the dispatching instruction |
| s1_valid_i | input | 1 | First source is used |
| s1_reg_i | input | REG_W | First source register |
| s2_valid_i | input | 1 | Second source is used |
| s2_reg_i | input | REG_W | Second source register |
| dst_valid_i | input | 1 | Instruction writes a register |
| dst_reg_i | input | REG_W | Destination register |
| cm_valid_i | input | 1 | A register-writing instruction commits |
| cm_idx_i | input | IDX_W | Window index of the committing instruction |
| cm_reg_i | input | REG_W | Register it wrote |
| arf1_data_i | input | DATA_W | Register file value for the first source |
| arf2_data_i | input | DATA_W | Register file value for the second source |
| probe1_hit_i | input | 1 | Value present at probe1 slot |
| probe1_data_i | input | DATA_W | Value read from probe1 slot |
| probe2_hit_i | input | 1 | Value present at probe2 slot |
| probe2_data_i | input | DATA_W | Value read from probe2 slot |
| probe1_slot_o | output | SLOT_W | Slot remembered for the first source's register |
| probe2_slot_o | output | SLOT_W | Slot remembered for the second source's register |
| s1_from_arf_o | output | 1 | First source reads the register file |
| s2_from_arf_o | output | 1 | Second source reads the register file |
| s1_ready_o | output | 1 | First source value known at dispatch |
| s1_data_o | output | DATA_W | First source value |
| s2_ready_o | output | 1 | Second source value known at dispatch |
| s2_data_o | output | DATA_W | Second source value |
| link1_we_o | output | 1 | Write pointer for first source |
| link1_at_o | output | SLOT_W | Slot receiving the first source pointer |
| link1_ptr_o | output | SLOT_W | Pointer value (first source slot) |
| link2_we_o | output | 1 | Write pointer for second source |
| link2_at_o | output | SLOT_W | Slot receiving the second source pointer |
| link2_ptr_o | output | SLOT_W | Pointer value (second source slot) |

## Verification
A wrong entry in the table is visible at the ports on the first later dispatch that reads that register. A stale slot shows as a wrong link target. A stale committed flag shows as a register file read where a link was due, or the reverse. The directed sequences therefore always follow an update (destination write, reader append, commit, flush) with a reader of the same register in the next cycle. Each reader's link target and register file flag are compared with slot numbers the bench works out as index times four plus field. Same-instruction orderings (source before destination, S2 behind S1) and same-cycle commit/dispatch races are driven on purpose, because a wrong priority there corrupts a chain without any other symptom.

// File: rtl/rct_pkg.sv
package rct_pkg;
  // Width of the field code appended to a window index to form a slot address
  localparam int FLD_W = 2;

  // Field codes inside one window entry
  typedef enum logic [FLD_W-1:0] {
    FLD_S1  = 2'd0,
    FLD_S2  = 2'd1,
    FLD_DST = 2'd2
  } fld_e;
endpackage

// File: rtl/rct_table.sv
module rct_table
  import rct_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int IDX_W  = 6,
  localparam int REG_W  = $clog2(NREG),
  localparam int SLOT_W = IDX_W + FLD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  // two lookup ports, one per source
  input  logic [1:0][REG_W-1:0]  rd_reg,
  output logic [1:0]             rd_cmt,
  output logic [1:0][SLOT_W-1:0] rd_tail,
  // dispatch update
  input  logic                   upd_go,
  input  logic [1:0]             src_live,
  input  logic [1:0][REG_W-1:0]  src_reg,
  input  logic [1:0][SLOT_W-1:0] src_slot,
  input  logic                   dst_valid,
  input  logic [REG_W-1:0]       dst_reg,
  input  logic [SLOT_W-1:0]      dst_slot,
  input  logic [IDX_W-1:0]       disp_idx,
  // commit
  input  logic                   cm_valid,
  input  logic [REG_W-1:0]       cm_reg,
  input  logic [IDX_W-1:0]       cm_idx,
  output logic [NREG-1:0]        cmt_vec
);

  logic [NREG-1:0]             cmt_q;
  logic [NREG-1:0][SLOT_W-1:0] tail_q;
  logic [NREG-1:0][IDX_W-1:0]  wr_q;

  // true when register r is named by the given port
  function automatic logic names(input logic [REG_W-1:0] sel, input int r);
    return sel == REG_W'(r);
  endfunction

  // commit match: register is in flight and still owned by the committer
  function automatic logic owner_commits(input logic c, input logic [IDX_W-1:0] w,
                                         input logic v, input logic [IDX_W-1:0] ci);
    return v && !c && (w == ci);
  endfunction

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      rd_cmt[p]  = cmt_q[rd_reg[p]];
      rd_tail[p] = tail_q[rd_reg[p]];
    end
  end

  assign cmt_vec = cmt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmt_q  <= '1;
      tail_q <= '0;
      wr_q   <= '0;
    end else if (flush) begin
      cmt_q <= '1;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        // commit first: a same-cycle new writer below overrides it
        if (names(cm_reg, r) && owner_commits(cmt_q[r], wr_q[r], cm_valid, cm_idx))
          cmt_q[r] <= 1'b1;
        // readers append in source order
        if (upd_go && src_live[0] && names(src_reg[0], r))
          tail_q[r] <= src_slot[0];
        if (upd_go && src_live[1] && names(src_reg[1], r))
          tail_q[r] <= src_slot[1];
        // destination claims the entry last
        if (upd_go && dst_valid && names(dst_reg, r)) begin
          tail_q[r] <= dst_slot;
          wr_q[r]   <= disp_idx;
          cmt_q[r]  <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/rct_src_resolve.sv
module rct_src_resolve
  import rct_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32,
  localparam int SLOT_W = IDX_W + FLD_W
) (
  input  logic              go,
  input  logic              sv,
  input  logic              cmt,
  input  logic [SLOT_W-1:0] tail,
  input  logic [SLOT_W-1:0] own_slot,
  // same-instruction predecessor (S2 behind S1)
  input  logic              alias_en,
  input  logic [SLOT_W-1:0] alias_slot,
  input  logic              alias_ready,
  input  logic [DATA_W-1:0] alias_data,
  input  logic [DATA_W-1:0] arf_data,
  input  logic              probe_hit,
  input  logic [DATA_W-1:0] probe_data,
  output logic              from_arf,
  output logic              live,
  output logic              link_we,
  output logic [SLOT_W-1:0] link_at,
  output logic [SLOT_W-1:0] link_ptr,
  output logic              ready,
  output logic [DATA_W-1:0] data
);

  logic used;
  assign used     = go && sv;
  assign from_arf = used && cmt;
  assign live     = used && !cmt;
  assign link_we  = live;
  assign link_at  = alias_en ? alias_slot : tail;
  assign link_ptr = own_slot;

  always_comb begin
    ready = 1'b0;
    data  = '0;
    if (from_arf) begin
      ready = 1'b1;
      data  = arf_data;
    end else if (live) begin
      ready = alias_en ? alias_ready : probe_hit;
      data  = alias_en ? alias_data  : probe_data;
    end
  end

endmodule

// File: rtl/rct_chain_linker.sv
module rct_chain_linker
  import rct_pkg::*;
#(
  parameter int NREG      = 32,
  parameter int WIN_DEPTH = 64,
  parameter int DATA_W    = 32,
  localparam int REG_W  = $clog2(NREG),
  localparam int IDX_W  = $clog2(WIN_DEPTH),
  localparam int SLOT_W = IDX_W + FLD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              disp_valid_i,
  input  logic [IDX_W-1:0]  disp_idx_i,
  input  logic              s1_valid_i,
  input  logic [REG_W-1:0]  s1_reg_i,
  input  logic              s2_valid_i,
  input  logic [REG_W-1:0]  s2_reg_i,
  input  logic              dst_valid_i,
  input  logic [REG_W-1:0]  dst_reg_i,
  input  logic              cm_valid_i,
  input  logic [IDX_W-1:0]  cm_idx_i,
  input  logic [REG_W-1:0]  cm_reg_i,
  input  logic [DATA_W-1:0] arf1_data_i,
  input  logic [DATA_W-1:0] arf2_data_i,
  input  logic              probe1_hit_i,
  input  logic [DATA_W-1:0] probe1_data_i,
  input  logic              probe2_hit_i,
  input  logic [DATA_W-1:0] probe2_data_i,
  output logic [SLOT_W-1:0] probe1_slot_o,
  output logic [SLOT_W-1:0] probe2_slot_o,
  output logic              s1_from_arf_o,
  output logic              s2_from_arf_o,
  output logic              s1_ready_o,
  output logic [DATA_W-1:0] s1_data_o,
  output logic              s2_ready_o,
  output logic [DATA_W-1:0] s2_data_o,
  output logic              link1_we_o,
  output logic [SLOT_W-1:0] link1_at_o,
  output logic [SLOT_W-1:0] link1_ptr_o,
  output logic              link2_we_o,
  output logic [SLOT_W-1:0] link2_at_o,
  output logic [SLOT_W-1:0] link2_ptr_o
);

  function automatic logic [SLOT_W-1:0] slot_of(input logic [IDX_W-1:0] idx, input fld_e f);
    return {idx, f};
  endfunction

  // named internal events for the checker
  logic                   disp_go;
  logic [NREG-1:0]        cmt_vec;
  logic [1:0]             rd_cmt;
  logic [1:0][SLOT_W-1:0] rd_tail;
  logic [SLOT_W-1:0]      s1_slot, s2_slot, d_slot;
  logic                   s1_live, s2_live;
  logic                   s2_alias;

  assign disp_go  = disp_valid_i && !flush_i;
  assign s1_slot  = slot_of(disp_idx_i, FLD_S1);
  assign s2_slot  = slot_of(disp_idx_i, FLD_S2);
  assign d_slot   = slot_of(disp_idx_i, FLD_DST);
  assign s2_alias = s1_valid_i && (s1_reg_i == s2_reg_i);

  rct_table #(.NREG(NREG), .IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_i),
    .rd_reg   ({s2_reg_i, s1_reg_i}),
    .rd_cmt   (rd_cmt),
    .rd_tail  (rd_tail),
    .upd_go   (disp_go),
    .src_live ({s2_live, s1_live}),
    .src_reg  ({s2_reg_i, s1_reg_i}),
    .src_slot ({s2_slot, s1_slot}),
    .dst_valid(dst_valid_i),
    .dst_reg  (dst_reg_i),
    .dst_slot (d_slot),
    .disp_idx (disp_idx_i),
    .cm_valid (cm_valid_i),
    .cm_reg   (cm_reg_i),
    .cm_idx   (cm_idx_i),
    .cmt_vec  (cmt_vec)
  );

  assign probe1_slot_o = rd_tail[0];
  assign probe2_slot_o = rd_tail[1];

  rct_src_resolve #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_src1 (
    .go         (disp_go),
    .sv         (s1_valid_i),
    .cmt        (rd_cmt[0]),
    .tail       (rd_tail[0]),
    .own_slot   (s1_slot),
    .alias_en   (1'b0),
    .alias_slot ('0),
    .alias_ready(1'b0),
    .alias_data ('0),
    .arf_data   (arf1_data_i),
    .probe_hit  (probe1_hit_i),
    .probe_data (probe1_data_i),
    .from_arf   (s1_from_arf_o),
    .live       (s1_live),
    .link_we    (link1_we_o),
    .link_at    (link1_at_o),
    .link_ptr   (link1_ptr_o),
    .ready      (s1_ready_o),
    .data       (s1_data_o)
  );

  rct_src_resolve #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_src2 (
    .go         (disp_go),
    .sv         (s2_valid_i),
    .cmt        (rd_cmt[1]),
    .tail       (rd_tail[1]),
    .own_slot   (s2_slot),
    .alias_en   (s2_alias),
    .alias_slot (s1_slot),
    .alias_ready(s1_ready_o),
    .alias_data (s1_data_o),
    .arf_data   (arf2_data_i),
    .probe_hit  (probe2_hit_i),
    .probe_data (probe2_data_i),
    .from_arf   (s2_from_arf_o),
    .live       (s2_live),
    .link_we    (link2_we_o),
    .link_at    (link2_at_o),
    .link_ptr   (link2_ptr_o),
    .ready      (s2_ready_o),
    .data       (s2_data_o)
  );

endmodule

// File: rtl/rct_chain_linker_chk.sv
module rct_chain_linker_chk #(
  parameter int NREG   = 32,
  parameter int IDX_W  = 6,
  parameter int REG_W  = 5,
  parameter int SLOT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_i,
  input logic              disp_valid_i,
  input logic [IDX_W-1:0]  disp_idx_i,
  input logic              s1_valid_i,
  input logic [REG_W-1:0]  s1_reg_i,
  input logic [REG_W-1:0]  s2_reg_i,
  input logic              dst_valid_i,
  input logic [REG_W-1:0]  dst_reg_i,
  input logic              s1_from_arf_o,
  input logic              s1_ready_o,
  input logic              link1_we_o,
  input logic [SLOT_W-1:0] link1_ptr_o,
  input logic              link2_we_o,
  input logic [SLOT_W-1:0] link2_at_o,
  input logic [NREG-1:0]   cmt_vec
);

  // R9
  flush_all_cmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cmt_vec == '1));

  // R9
  flush_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> (!link1_we_o && !link2_we_o));

  // R3 R10
  dst_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid_i && !flush_i && dst_valid_i) |=> !cmt_vec[$past(dst_reg_i)]);

  // R2
  arf_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_from_arf_o |-> (s1_ready_o && !link1_we_o));

  // R4
  link_ptr_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link1_we_o |-> (link1_ptr_o == {disp_idx_i, 2'd0}));

  // R7
  dual_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link2_we_o && s1_valid_i && (s1_reg_i == s2_reg_i)) |-> (link2_at_o == {disp_idx_i, 2'd0}));

  // R1
  link_needs_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link1_we_o || link2_we_o) |-> disp_valid_i);

endmodule

bind rct_chain_linker rct_chain_linker_chk #(
  .NREG(NREG), .IDX_W(IDX_W), .REG_W(REG_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush_i      (flush_i),
  .disp_valid_i (disp_valid_i),
  .disp_idx_i   (disp_idx_i),
  .s1_valid_i   (s1_valid_i),
  .s1_reg_i     (s1_reg_i),
  .s2_reg_i     (s2_reg_i),
  .dst_valid_i  (dst_valid_i),
  .dst_reg_i    (dst_reg_i),
  .s1_from_arf_o(s1_from_arf_o),
  .s1_ready_o   (s1_ready_o),
  .link1_we_o   (link1_we_o),
  .link1_ptr_o  (link1_ptr_o),
  .link2_we_o   (link2_we_o),
  .link2_at_o   (link2_at_o),
  .cmt_vec      (cmt_vec)
);

// File: tb/rct_chain_linker_test.sv
module rct_chain_linker_test;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W  = 6;
  localparam int REG_W  = 5;
  localparam int SLOT_W = 8;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_i = 1'b0;
  logic disp_valid_i = 1'b0;
  logic [IDX_W-1:0] disp_idx_i = '0;
  logic s1_valid_i = 1'b0, s2_valid_i = 1'b0, dst_valid_i = 1'b0;
  logic [REG_W-1:0] s1_reg_i = '0, s2_reg_i = '0, dst_reg_i = '0;
  logic cm_valid_i = 1'b0;
  logic [IDX_W-1:0] cm_idx_i = '0;
  logic [REG_W-1:0] cm_reg_i = '0;
  logic [DATA_W-1:0] arf1_data_i = 32'hAAAA_0001, arf2_data_i = 32'hBBBB_0002;
  logic probe1_hit_i = 1'b0, probe2_hit_i = 1'b0;
  logic [DATA_W-1:0] probe1_data_i = '0, probe2_data_i = '0;
  logic [SLOT_W-1:0] probe1_slot_o, probe2_slot_o;
  logic s1_from_arf_o, s2_from_arf_o, s1_ready_o, s2_ready_o;
  logic [DATA_W-1:0] s1_data_o, s2_data_o;
  logic link1_we_o, link2_we_o;
  logic [SLOT_W-1:0] link1_at_o, link1_ptr_o, link2_at_o, link2_ptr_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rct_chain_linker uut (.*);

  // slot address worked out arithmetically: four slots per window entry
  function automatic int slot(input int idx, input int fld);
    return idx * 4 + fld;
  endfunction

  task automatic chk(input string tag, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic quiet();
    disp_valid_i = 0; s1_valid_i = 0; s2_valid_i = 0; dst_valid_i = 0;
    cm_valid_i = 0; flush_i = 0; probe1_hit_i = 0; probe2_hit_i = 0;
  endtask

  task automatic drive(input int idx, input bit v1, input int r1, input bit v2, input int r2,
                       input bit vd, input int rd);
    quiet();
    disp_valid_i = 1; disp_idx_i = IDX_W'(idx);
    s1_valid_i = v1; s1_reg_i = REG_W'(r1);
    s2_valid_i = v2; s2_reg_i = REG_W'(r2);
    dst_valid_i = vd; dst_reg_i = REG_W'(rd);
  endtask

  task automatic commit(input int idx, input int r);
    quiet();
    cm_valid_i = 1; cm_idx_i = IDX_W'(idx); cm_reg_i = REG_W'(r);
    @(negedge clk);
  endtask

  task automatic t_reset();
    drive(1, 1, 5, 0, 0, 0, 0);
    #1;
    chk("R1 arf flag", s1_from_arf_o, 1);
    chk("R1 ready", s1_ready_o, 1);
    chk("R1 data", s1_data_o, arf1_data_i);
    chk("R1 no link", link1_we_o, 0);
    @(negedge clk);
  endtask

  task automatic t_writer_reader();
    drive(3, 0, 0, 0, 0, 1, 5);
    @(negedge clk);
    drive(4, 1, 5, 0, 0, 0, 0);
    #1;
    chk("R3 not arf", s1_from_arf_o, 0);
    chk("R3 link at D", link1_at_o, slot(3, 2));
    chk("R4 link ptr", link1_ptr_o, slot(4, 0));
    chk("R5 probe slot", probe1_slot_o, slot(3, 2));
    chk("R5 not ready", s1_ready_o, 0);
    @(negedge clk);
    drive(5, 0, 0, 1, 5, 0, 0);
    probe2_hit_i = 1; probe2_data_i = 32'h99;
    #1;
    chk("R4 link behind reader", link2_at_o, slot(4, 0));
    chk("R4 link2 ptr", link2_ptr_o, slot(5, 1));
    chk("R5 ready on hit", s2_ready_o, 1);
    chk("R5 captured data", s2_data_o, 32'h99);
    @(negedge clk);
  endtask

  task automatic t_commit();
    commit(9, 5);
    drive(6, 1, 5, 0, 0, 0, 0);
    #1;
    chk("R8 foreign commit ignored", s1_from_arf_o, 0);
    chk("R8 chain kept", link1_at_o, slot(5, 1));
    @(negedge clk);
    commit(3, 5);
    drive(7, 1, 5, 0, 0, 0, 0);
    #1;
    chk("R8 owner commit to arf", s1_from_arf_o, 1);
    chk("R8 no link", link1_we_o, 0);
    chk("R8 arf data", s1_data_o, arf1_data_i);
    @(negedge clk);
  endtask

  task automatic t_src_dst_same();
    drive(10, 0, 0, 0, 0, 1, 7);
    @(negedge clk);
    drive(11, 1, 7, 0, 0, 1, 7);
    #1;
    chk("R6 source sees old entry", link1_at_o, slot(10, 2));
    @(negedge clk);
    drive(12, 1, 7, 0, 0, 0, 0);
    #1;
    chk("R6 dest overrides source tail", link1_at_o, slot(11, 2));
    @(negedge clk);
  endtask

  task automatic t_dual();
    drive(13, 1, 7, 1, 7, 0, 0);
    probe1_hit_i = 1; probe1_data_i = 32'h55;
    #1;
    chk("R7 s1 link at", link1_at_o, slot(12, 0));
    chk("R7 s2 link at own s1", link2_at_o, slot(13, 0));
    chk("R7 s2 ptr", link2_ptr_o, slot(13, 1));
    chk("R7 s2 ready mirrors", s2_ready_o, 1);
    chk("R7 s2 data mirrors", s2_data_o, 32'h55);
    @(negedge clk);
    drive(14, 1, 7, 0, 0, 0, 0);
    #1;
    chk("R7 tail on s2", link1_at_o, slot(13, 1));
    @(negedge clk);
  endtask

  task automatic t_committed_dual();
    drive(15, 1, 9, 1, 9, 0, 0);
    #1;
    chk("R2 s1 arf", s1_from_arf_o, 1);
    chk("R2 s2 arf", s2_from_arf_o, 1);
    chk("R2 no link2", link2_we_o, 0);
    chk("R2 s2 data", s2_data_o, arf2_data_i);
    @(negedge clk);
    drive(16, 0, 0, 1, 9, 0, 0);
    #1;
    chk("R2 entry untouched", s2_from_arf_o, 1);
    @(negedge clk);
  endtask

  task automatic t_commit_race();
    drive(20, 0, 0, 0, 0, 1, 12);
    @(negedge clk);
    drive(21, 0, 0, 0, 0, 1, 12);
    cm_valid_i = 1; cm_idx_i = IDX_W'(20); cm_reg_i = REG_W'(12);
    @(negedge clk);
    drive(22, 1, 12, 0, 0, 0, 0);
    #1;
    chk("R10 new writer kept", s1_from_arf_o, 0);
    chk("R10 link at new D", link1_at_o, slot(21, 2));
    @(negedge clk);
  endtask

  task automatic t_flush();
    drive(30, 1, 12, 0, 0, 1, 13);
    flush_i = 1;
    #1;
    chk("R9 no link in flush", link1_we_o, 0);
    @(negedge clk);
    drive(31, 1, 12, 1, 13, 0, 0);
    #1;
    chk("R9 r12 committed", s1_from_arf_o, 1);
    chk("R9 r13 dispatch dropped", s2_from_arf_o, 1);
    @(negedge clk);
    drive(32, 1, 7, 0, 0, 0, 0);
    #1;
    chk("R9 r7 committed", s1_from_arf_o, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_writer_reader();
    t_commit();
    t_src_dst_same();
    t_dual();
    t_committed_dual();
    t_commit_race();
    t_flush();
    quiet();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule